// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This controller sits above a byte-level I2C master. It turns a single request into the chain of I2C transactions that a paged, indirect register file needs. The target register file is reached through three consecutive device registers: a page/target select register, a data register one above it, and a command register two above it. An indirect write is one auto-incrementing write into that triplet. An indirect read is a similar write that carries a read command, followed by a settle wait and a repeated-START read of the data register. The block also offers a plain direct read of any device register and a readiness poll on the command register.

The requester sees a simple port. It presents an operation, a target register and a write value for one cycle while the block is idle. It then waits for a one-cycle completion pulse, which carries an error flag and the last byte read. Downstream, the block issues one byte-level command at a time (START, WRITE byte, READ byte with a last-byte flag, STOP) and waits for the byte engine's completion, which reports the acknowledge result and any received byte. Waits are timed by a millisecond counter derived from the clock frequency parameter.

Top module: `indirect_reg_seq`

## Requirements
- R1: Following reset, `busy`, `done`, `err` and `eng_cmd_valid` are all low.
- R2: A request is taken only while `busy` is low. `busy` rises the cycle after acceptance and stays high through the single-cycle `done` pulse, then drops. A request presented while busy is ignored and starts no commands.
- R3: Operation code 0 (indirect write) issues START, WRITE 0x10, WRITE 0xA6, WRITE target, WRITE value, WRITE 0x03, STOP, then completes with `err`=0. Engine command codes are 0=START, 1=WRITE, 2=READ, 3=STOP.
- R4: Operation code 1 (indirect read) issues START, WRITE 0x10, WRITE 0xA6, WRITE target, WRITE 0x00, WRITE 0x01, STOP. It then waits at least READ_WAIT_MS milliseconds and issues START, WRITE 0x10, WRITE 0xA7, START with no STOP in between, WRITE 0x11, READ, STOP. `rdata` holds the byte read.
- R5: Operation code 2 (direct read) issues START, WRITE 0x10, WRITE target, START, WRITE 0x11, READ, STOP, and returns the byte read on `rdata` with `err`=0.
- R6: Operation code 3 (ready poll) performs a direct read of register 0xA8. If bit 0 of the byte read is clear, it completes with `err`=0 and that byte on `rdata`.
- R7: While the polled bit 0 stays set, the poll waits at least POLL_GAP_MS milliseconds and retries. After POLL_TRIES (20) failed tries it completes with `err`=1 and issues no further reads.
- R8: A missing acknowledge on any written address or data byte is followed directly by a STOP with no further bytes. Outside a poll, the request then completes with `err`=1.
- R9: Inside a poll, a missing acknowledge counts as one failed try. It is followed by the STOP, the gap and a retry, just like a busy status.
- R10: Each READ command is issued with `eng_last` high, so the last-byte flag is set before the single byte is taken and STOP follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 2 | Operation: 0 ind. write, 1 ind. read, 2 direct read, 3 poll |
| req_reg | input | 8 | Target register |
| req_wdata | input | 8 | Value for an indirect write |
| busy | output | 1 | High from acceptance through the done pulse |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| rdata | output | 8 | Last byte read |
| eng_cmd_valid | output | 1 | One-cycle command strobe to the byte engine |
| eng_cmd | output | 2 | Command: 0 START, 1 WRITE, 2 READ, 3 STOP |
| eng_wbyte | output | 8 | Byte to write |
| eng_last | output | 1 | Last-byte flag for READ |
| eng_done | input | 1 | Byte engine finished the current command |
| eng_ack | input | 1 | Acknowledge received, valid with eng_done for WRITE |
| eng_rbyte | input | 8 | Received byte, valid with eng_done for READ |

## Verification
The embedded assertions cover the cycle-level rules on every cycle. They check the busy/done/err framing, that commands go out only while busy, that every READ carries the last flag, that a refused byte is followed by a STOP two cycles later, that the timer is never restarted while running, and that the try counter never steps past the final try. Only the bench scenarios can show the full byte order of each operation, the placement of the repeated START, and the settle and gap waits in real cycles. The same holds for the count of 20 tries before a timeout, the recovery of a poll after a refused byte, and the fact that a request made while busy is dropped.

// File: rtl/irs_pkg.sv
// Shared types of the indirect register access sequencer.
// Assumes: the request op and engine command encodings are fixed (see brief).
package irs_pkg;

    typedef enum logic [1:0] {
        OP_IWRITE = 2'd0,
        OP_IREAD  = 2'd1,
        OP_DREAD  = 2'd2,
        OP_POLL   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        EC_START = 2'd0,
        EC_WRITE = 2'd1,
        EC_READ  = 2'd2,
        EC_STOP  = 2'd3
    } eng_cmd_e;

    typedef enum logic [2:0] {
        U_START, U_WR, U_RD, U_STOP, U_WAIT, U_PCHK, U_END
    } uop_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_ENG, S_TMR, S_ABRT, S_ABRTW, S_GAP, S_DONE
    } st_e;

endpackage

// File: rtl/irs_ucode.sv
// Step table: maps (operation, step) to one micro-operation and its byte.
// Assumes: data register = page register + 1, command register = page + 2
// (auto-increment on the device). Purely combinational.
module irs_ucode
    import irs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h08,
    parameter logic [7:0] PAGE_REG = 8'hA6,
    parameter logic [7:0] WR_CODE  = 8'h03,
    parameter logic [7:0] RD_CODE  = 8'h01
) (
    input  op_e         op,
    input  logic [3:0]  step,
    input  logic [7:0]  tgt,
    input  logic [7:0]  wval,
    output uop_e        kind,
    output logic [7:0]  byt
);
    localparam logic [7:0] ADDR_W   = {DEV_ADDR, 1'b0};
    localparam logic [7:0] ADDR_R   = {DEV_ADDR, 1'b1};
    localparam logic [7:0] DATA_REG = PAGE_REG + 8'd1;
    localparam logic [7:0] CMD_REG  = PAGE_REG + 8'd2;

    logic [2:0] rd_idx;   // position inside a direct-read transaction
    logic [7:0] rd_reg;   // register that transaction addresses
    uop_e       rd_kind;
    logic [7:0] rd_byt;
    uop_e       wr_kind;
    logic [7:0] wr_byt;

    // Direct read with repeated START: START, addr+W, reg, START, addr+R, READ, STOP.
    always_comb begin
        rd_kind = U_END;
        rd_byt  = 8'h00;
        case (rd_idx)
            3'd0: rd_kind = U_START;
            3'd1: begin rd_kind = U_WR; rd_byt = ADDR_W; end
            3'd2: begin rd_kind = U_WR; rd_byt = rd_reg; end
            3'd3: rd_kind = U_START;
            3'd4: begin rd_kind = U_WR; rd_byt = ADDR_R; end
            3'd5: rd_kind = U_RD;
            3'd6: rd_kind = U_STOP;
            default: rd_kind = U_END;
        endcase
    end

    // Triplet write: START, addr+W, page reg, target, value/placeholder, command, STOP.
    always_comb begin
        wr_kind = U_END;
        wr_byt  = 8'h00;
        case (step)
            4'd0: wr_kind = U_START;
            4'd1: begin wr_kind = U_WR; wr_byt = ADDR_W; end
            4'd2: begin wr_kind = U_WR; wr_byt = PAGE_REG; end
            4'd3: begin wr_kind = U_WR; wr_byt = tgt; end
            4'd4: begin wr_kind = U_WR; wr_byt = (op == OP_IWRITE) ? wval : 8'h00; end
            4'd5: begin wr_kind = U_WR; wr_byt = (op == OP_IWRITE) ? WR_CODE : RD_CODE; end
            4'd6: wr_kind = U_STOP;
            default: wr_kind = U_END;
        endcase
    end

    // Select the step source per operation.
    always_comb begin
        rd_idx = step[2:0];
        rd_reg = tgt;
        kind   = U_END;
        byt    = 8'h00;
        unique case (op)
            OP_IWRITE: begin kind = wr_kind; byt = wr_byt; end
            OP_IREAD: begin
                rd_idx = 3'(step - 4'd8);
                rd_reg = DATA_REG;
                if (step < 4'd7) begin
                    kind = wr_kind; byt = wr_byt;
                end else if (step == 4'd7) begin
                    kind = U_WAIT;
                end else begin
                    kind = (step == 4'd15) ? U_END : rd_kind;
                    byt  = rd_byt;
                end
            end
            OP_DREAD: begin
                kind = (step < 4'd7) ? rd_kind : U_END;
                byt  = rd_byt;
            end
            OP_POLL: begin
                rd_reg = CMD_REG;
                kind = (step < 4'd7) ? rd_kind : U_PCHK;
                byt  = rd_byt;
            end
        endcase
    end

endmodule

// File: rtl/irs_ms_timer.sv
// One-shot wait timer with two preset lengths (settle wait, poll gap).
// Assumes: go is a single-cycle pulse and is never given while running.
// fire is high for one cycle when the selected length has elapsed.
module irs_ms_timer #(
    parameter int SHORT_CYC = 1000,
    parameter int LONG_CYC  = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic long_sel,
    output logic fire
);
    localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic          run;

    assign fire = run && (cnt == '0);

    // Load on go, count down while running, stop after firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (go) begin
            run <= 1'b1;
            cnt <= long_sel ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    AST_TMR_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n) go |-> !run); // R4

endmodule

// File: rtl/irs_try_counter.sv
// Counts failed poll tries of the current request.
// Assumes: clr at acceptance, inc once per failed try; last marks the final try.
module irs_try_counter #(
    parameter int TRIES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(TRIES + 1);

    logic [CW-1:0] cnt;

    assign last = (cnt == CW'(TRIES - 1));

    // Clear per request, step on each failed try.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n) inc |-> !last); // R7

endmodule

// File: rtl/indirect_reg_seq.sv
// Indirect register access sequencer: runs the step table for one request,
// drives the byte engine one command at a time, handles refused bytes,
// settle waits and poll retries.
// Assumes: the byte engine answers each command with eng_done no earlier
// than the cycle after eng_cmd_valid; eng_ack is meaningful for WRITE only.
module indirect_reg_seq
    import irs_pkg::*;
#(
    parameter int         CLK_HZ       = 48_000_000,
    parameter logic [6:0] DEV_ADDR     = 7'h08,
    parameter logic [7:0] PAGE_REG     = 8'hA6,
    parameter int         READ_WAIT_MS = 1,
    parameter int         POLL_GAP_MS  = 5,
    parameter int         POLL_TRIES   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic [7:0] req_reg,
    input  logic [7:0] req_wdata,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic [7:0] rdata,
    output logic       eng_cmd_valid,
    output logic [1:0] eng_cmd,
    output logic [7:0] eng_wbyte,
    output logic       eng_last,
    input  logic       eng_done,
    input  logic       eng_ack,
    input  logic [7:0] eng_rbyte
);
    localparam int MS_CYC = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;

    st_e        state;
    op_e        op_q;
    logic [7:0] reg_q, wd_q, rdata_q, wbyte_q;
    logic [3:0] step;
    eng_cmd_e   cmd_q;
    logic       cmd_v_q, last_q, busy_q, done_q, err_q;
    logic       tmr_go, tmr_long, tmr_fire;
    logic       try_clr, try_inc, try_last;
    uop_e       uk;
    logic [7:0] ub;

    irs_ucode #(.DEV_ADDR(DEV_ADDR), .PAGE_REG(PAGE_REG)) u_ucode (
        .op(op_q), .step(step), .tgt(reg_q), .wval(wd_q), .kind(uk), .byt(ub)
    );

    irs_ms_timer #(.SHORT_CYC(READ_WAIT_MS * MS_CYC), .LONG_CYC(POLL_GAP_MS * MS_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(tmr_go), .long_sel(tmr_long), .fire(tmr_fire)
    );

    irs_try_counter #(.TRIES(POLL_TRIES)) u_tries (
        .clk(clk), .rst_n(rst_n), .clr(try_clr), .inc(try_inc), .last(try_last)
    );

    assign busy          = busy_q;
    assign done          = done_q;
    assign err           = err_q;
    assign rdata         = rdata_q;
    assign eng_cmd_valid = cmd_v_q;
    assign eng_cmd       = cmd_q;
    assign eng_wbyte     = wbyte_q;
    assign eng_last      = last_q;

    // Request sequencing: fetch a step, run it, advance, abort or retry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_q     <= OP_IWRITE;
            reg_q    <= 8'h00;
            wd_q     <= 8'h00;
            rdata_q  <= 8'h00;
            wbyte_q  <= 8'h00;
            step     <= 4'd0;
            cmd_q    <= EC_START;
            cmd_v_q  <= 1'b0;
            last_q   <= 1'b0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            tmr_go   <= 1'b0;
            tmr_long <= 1'b0;
            try_clr  <= 1'b0;
            try_inc  <= 1'b0;
        end else begin
            cmd_v_q <= 1'b0;
            tmr_go  <= 1'b0;
            try_clr <= 1'b0;
            try_inc <= 1'b0;
            case (state)
                S_IDLE: if (req_valid) begin
                    op_q    <= op_e'(req_op);
                    reg_q   <= req_reg;
                    wd_q    <= req_wdata;
                    step    <= 4'd0;
                    busy_q  <= 1'b1;
                    try_clr <= 1'b1;
                    state   <= S_FETCH;
                end
                S_FETCH: case (uk)
                    U_START, U_WR, U_RD, U_STOP: begin
                        cmd_v_q <= 1'b1;
                        cmd_q   <= (uk == U_START) ? EC_START :
                                   (uk == U_WR)    ? EC_WRITE :
                                   (uk == U_RD)    ? EC_READ  : EC_STOP;
                        wbyte_q <= ub;
                        last_q  <= (uk == U_RD);
                        state   <= S_ENG;
                    end
                    U_WAIT: begin
                        tmr_go   <= 1'b1;
                        tmr_long <= 1'b0;
                        state    <= S_TMR;
                    end
                    U_PCHK: begin
                        if (!rdata_q[0] || try_last) begin
                            done_q <= 1'b1;
                            err_q  <= rdata_q[0];
                            state  <= S_DONE;
                        end else begin
                            try_inc  <= 1'b1;
                            tmr_go   <= 1'b1;
                            tmr_long <= 1'b1;
                            state    <= S_GAP;
                        end
                    end
                    default: begin
                        done_q <= 1'b1;
                        err_q  <= 1'b0;
                        state  <= S_DONE;
                    end
                endcase
                S_ENG: if (eng_done) begin
                    if (cmd_q == EC_WRITE && !eng_ack) begin
                        state <= S_ABRT;
                    end else begin
                        if (cmd_q == EC_READ) rdata_q <= eng_rbyte;
                        step  <= step + 4'd1;
                        state <= S_FETCH;
                    end
                end
                S_TMR: if (tmr_fire) begin
                    step  <= step + 4'd1;
                    state <= S_FETCH;
                end
                S_ABRT: begin
                    cmd_v_q <= 1'b1;
                    cmd_q   <= EC_STOP;
                    last_q  <= 1'b0;
                    wbyte_q <= 8'h00;
                    state   <= S_ABRTW;
                end
                S_ABRTW: if (eng_done) begin
                    if (op_q == OP_POLL && !try_last) begin
                        try_inc  <= 1'b1;
                        tmr_go   <= 1'b1;
                        tmr_long <= 1'b1;
                        state    <= S_GAP;
                    end else begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                        state  <= S_DONE;
                    end
                end
                S_GAP: if (tmr_fire) begin
                    step  <= 4'd0;
                    state <= S_FETCH;
                end
                S_DONE: begin
                    done_q <= 1'b0;
                    err_q  <= 1'b0;
                    busy_q <= 1'b0;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_DONE_IN_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R2
    AST_BUSY_DROPS:     assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy && !done); // R2
    AST_CMD_IN_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) eng_cmd_valid |-> busy); // R2
    AST_ERR_WITH_DONE:  assert property (@(posedge clk) disable iff (!rst_n) err |-> done); // R8
    AST_READ_LAST:      assert property (@(posedge clk) disable iff (!rst_n) (eng_cmd_valid && eng_cmd == EC_READ) |-> eng_last); // R10
    AST_NACK_STOP:      assert property (@(posedge clk) disable iff (!rst_n)
                            (state == S_ENG && eng_done && cmd_q == EC_WRITE && !eng_ack) |=> ##1 (eng_cmd_valid && eng_cmd == EC_STOP)); // R8

endmodule

// File: tb/test_indirect_reg_seq.sv
`timescale 1ns/1ps
module test_indirect_reg_seq;
    localparam int CLK_HZ = 8000;
    localparam int MS     = CLK_HZ / 1000;
    localparam int GAP    = 5 * MS;

    typedef struct packed {
        logic [1:0]  k;
        logic [7:0]  b;
        logic        l;
        logic [15:0] gap;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [7:0] req_reg = 8'h00;
    logic [7:0] req_wdata = 8'h00;
    logic       busy, done, err, eng_cmd_valid, eng_last;
    logic [7:0] rdata, eng_wbyte;
    logic [1:0] eng_cmd;
    logic       eng_done = 1'b0;
    logic       eng_ack = 1'b0;
    logic [7:0] eng_rbyte = 8'h00;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    int    last_done_cyc = 0;
    int    wr_cnt = 0;
    int    nack_idx = -1;
    string cur_req = "R1";
    item_t expq[$];
    logic [7:0] rdq[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    indirect_reg_seq #(.CLK_HZ(CLK_HZ)) i_indirect_reg_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
        .err(err), .rdata(rdata), .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd),
        .eng_wbyte(eng_wbyte), .eng_last(eng_last), .eng_done(eng_done),
        .eng_ack(eng_ack), .eng_rbyte(eng_rbyte)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Driver-side helpers: push expected engine commands.
    task automatic push(input logic [1:0] k, input logic [7:0] b, input logic l, input int g);
        item_t it;
        it.k = k; it.b = b; it.l = l; it.gap = 16'(g);
        expq.push_back(it);
    endtask

    task automatic exp_dread(input logic [7:0] r, input int g);
        push(2'd0, 8'h00, 1'b0, g);
        push(2'd1, 8'h10, 1'b0, 0);
        push(2'd1, r,     1'b0, 0);
        push(2'd0, 8'h00, 1'b0, 0);
        push(2'd1, 8'h11, 1'b0, 0);
        push(2'd2, 8'h00, 1'b1, 0);
        push(2'd3, 8'h00, 1'b0, 0);
    endtask

    task automatic exp_triplet(input logic [7:0] r, input logic [7:0] v, input logic [7:0] c);
        push(2'd0, 8'h00, 1'b0, 0);
        push(2'd1, 8'h10, 1'b0, 0);
        push(2'd1, 8'hA6, 1'b0, 0);
        push(2'd1, r,     1'b0, 0);
        push(2'd1, v,     1'b0, 0);
        push(2'd1, c,     1'b0, 0);
        push(2'd3, 8'h00, 1'b0, 0);
    endtask

    // Byte engine model and scoreboard monitor.
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (eng_cmd_valid) begin
                logic       a;
                logic [7:0] rb;
                if (expq.size() == 0) begin
                    chk(1'b0, {cur_req, " R2 unexpected command"}, int'(eng_cmd), 0);
                end else begin
                    item_t it;
                    it = expq.pop_front();
                    chk(eng_cmd == it.k, {cur_req, " command code"}, int'(eng_cmd), int'(it.k));
                    if (it.k == 2'd1)
                        chk(eng_wbyte == it.b, {cur_req, " write byte"}, int'(eng_wbyte), int'(it.b));
                    chk(eng_last == it.l, {cur_req, " R10 last flag"}, int'(eng_last), int'(it.l));
                    if (it.gap != 0)
                        chk((cyc - last_done_cyc >= int'(it.gap)) && (cyc - last_done_cyc <= int'(it.gap) + 8),
                            {cur_req, " wait length"}, cyc - last_done_cyc, int'(it.gap));
                end
                a = 1'b1;
                if (eng_cmd == 2'd1) begin
                    if (wr_cnt == nack_idx) a = 1'b0;
                    wr_cnt++;
                end
                rb = 8'h00;
                if (eng_cmd == 2'd2 && rdq.size() > 0) rb = rdq.pop_front();
                @(negedge clk);
                eng_done = 1'b1;
                eng_ack = a;
                eng_rbyte = rb;
                last_done_cyc = cyc;
            end
        end
    end

    task automatic do_req(input logic [1:0] op, input logic [7:0] r, input logic [7:0] w,
                          input logic exp_err, input bit chk_rd, input logic [7:0] exp_rd,
                          input bit poke, input string tag);
        int n;
        cur_req = tag;
        wr_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_reg = r; req_wdata = w;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, {tag, " R2 busy after accept"}, int'(busy), 1);
        if (poke) begin
            req_valid = 1'b1; req_op = 2'd2; req_reg = 8'h55;
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, {tag, " done seen"}, int'(done), 1);
        chk(err == exp_err, {tag, " err flag"}, int'(err), int'(exp_err));
        if (chk_rd) chk(rdata == exp_rd, {tag, " rdata"}, int'(rdata), int'(exp_rd));
        chk(expq.size() == 0, {tag, " all commands issued"}, expq.size(), 0);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, {tag, " R2 idle after done"}, int'({busy, done}), 0);
        repeat (3) @(negedge clk);
        chk(expq.size() == 0, {tag, " no extra commands"}, expq.size(), 0);
        nack_idx = -1;
        expq.delete();
        rdq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk({busy, done, err, eng_cmd_valid} == 4'b0, "R1 reset outputs", int'({busy, done, err, eng_cmd_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, err, eng_cmd_valid} == 4'b0, "R1 after reset", int'({busy, done, err, eng_cmd_valid}), 0);

        // R3 indirect write
        exp_triplet(8'h3C, 8'h5A, 8'h03);
        do_req(2'd0, 8'h3C, 8'h5A, 1'b0, 0, 8'h00, 0, "R3 iwrite");

        // R4 indirect read with settle wait and repeated START
        exp_triplet(8'h07, 8'h00, 8'h01);
        exp_dread(8'hA7, MS);
        rdq.push_back(8'h9E);
        do_req(2'd1, 8'h07, 8'hFF, 1'b0, 1, 8'h9E, 0, "R4 iread");

        // R5 direct read
        exp_dread(8'hA2, 0);
        rdq.push_back(8'h41);
        do_req(2'd2, 8'hA2, 8'h00, 1'b0, 1, 8'h41, 0, "R5 dread");

        // R6 poll idle on first try
        exp_dread(8'hA8, 0);
        rdq.push_back(8'hFE);
        do_req(2'd3, 8'h00, 8'h00, 1'b0, 1, 8'hFE, 0, "R6 poll");

        // R7 poll busy twice then idle
        exp_dread(8'hA8, 0);
        exp_dread(8'hA8, GAP);
        exp_dread(8'hA8, GAP);
        rdq.push_back(8'h03); rdq.push_back(8'h81); rdq.push_back(8'h00);
        do_req(2'd3, 8'h00, 8'h00, 1'b0, 1, 8'h00, 0, "R7 poll retry");

        // R7 poll timeout after 20 tries
        for (int i = 0; i < 20; i++) begin
            exp_dread(8'hA8, (i == 0) ? 0 : GAP);
            rdq.push_back(8'h01);
        end
        do_req(2'd3, 8'h00, 8'h00, 1'b1, 1, 8'h01, 0, "R7 poll timeout");

        // R8 refused address byte on indirect write
        push(2'd0, 8'h00, 1'b0, 0);
        push(2'd1, 8'h10, 1'b0, 0);
        push(2'd3, 8'h00, 1'b0, 0);
        nack_idx = 0;
        do_req(2'd0, 8'h12, 8'h34, 1'b1, 0, 8'h00, 0, "R8 nack addr");

        // R8 refused read address in second phase of indirect read
        exp_triplet(8'h20, 8'h00, 8'h01);
        push(2'd0, 8'h00, 1'b0, MS);
        push(2'd1, 8'h10, 1'b0, 0);
        push(2'd1, 8'hA7, 1'b0, 0);
        push(2'd0, 8'h00, 1'b0, 0);
        push(2'd1, 8'h11, 1'b0, 0);
        push(2'd3, 8'h00, 1'b0, 0);
        nack_idx = 7;
        do_req(2'd1, 8'h20, 8'h00, 1'b1, 0, 8'h00, 0, "R8 nack read phase");

        // R9 refused byte inside poll counts as a failed try
        push(2'd0, 8'h00, 1'b0, 0);
        push(2'd1, 8'h10, 1'b0, 0);
        push(2'd1, 8'hA8, 1'b0, 0);
        push(2'd3, 8'h00, 1'b0, 0);
        exp_dread(8'hA8, GAP);
        rdq.push_back(8'h00);
        nack_idx = 1;
        do_req(2'd3, 8'h00, 8'h00, 1'b0, 1, 8'h00, 0, "R9 poll nack");

        // R2 request while busy is ignored
        exp_triplet(8'h44, 8'h99, 8'h03);
        do_req(2'd0, 8'h44, 8'h99, 1'b0, 0, 8'h00, 1, "R2 ignore while busy");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule